// File: doc/BRIEF.md
# Dock Instruction Ring Controller

This block owns the circular instruction store that sits inside a dock's pump. Words of 26 bits arrive from the switch fabric at the insertion point. They enter the ring directly, with no buffer in front of them, and leave it at the execution point. Ordinary words are offered in arrival order to an external executor over a valid/ready pair. For each word it accepts, the executor says what happens next: the word is dropped from the ring, written back behind the newest entry with a new count, or kept in place with a new count.

Three ring-control words are handled inside the block and never reach the executor:

- **Kill** stays at the insertion point and removes entries from the execution point. It removes one more entry than its count field.
- **Clog** is stored like any other word. Once it reaches the execution point it freezes execution there.
- **Unclog** waits at the insertion point until a clog sits at the execution point. It then removes that clog and is consumed itself.

A full ring holds off the fabric by keeping `in_ready` low.

Top module: `dock_ring`

## Requirements
- R1: After reset the ring is empty. `exec_valid` is low, and `in_ready` is high for a presented ordinary word.
- R2: Bits [25:23] select the word class: 3'b011 kill, 3'b001 clog, 3'b010 unclog, and every other value is ordinary. Ordinary words are offered on `exec_instr` in the order they were accepted, unchanged.
- R3: The ring holds at most DEPTH entries. With DEPTH entries stored, `in_ready` is low for an ordinary word or a clog, and no stored entry is lost.
- R4: The count field is bits [6:0]. `exec_action` 2'b00 or 2'b11 removes the accepted word. 2'b10 keeps it at the execution point with bits [6:0] replaced by `exec_count`. 2'b01 moves it behind the newest entry with bits [6:0] replaced by `exec_count`.
- R5: In a cycle where the executor requeues a word, no fabric word is taken.
- R6: While `exec_valid` is high and `exec_ready` is low, the offer stays up and `exec_instr` holds its value.
- R7: A clog at the execution point is never offered. No entry behind it is offered while it remains there.
- R8: An unclog is taken only in a cycle where a clog sits at the execution point. That clog and the unclog are then both removed.
- R9: A kill with count n removes the n+1 entries at the execution point, one per cycle, and is taken in the cycle of the last removal. It waits while the ring is empty or a clog is at the execution point.
- R10: While a kill is presented, no new offer is made to the executor. An offer already outstanding is kept until the executor accepts it, and only then does the kill begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| in_valid | input | 1 | Fabric word present |
| in_ready | output | 1 | Fabric word taken this cycle when in_valid is high |
| in_data | input | 26 | Fabric word |
| exec_valid | output | 1 | Word at execution point offered to the executor |
| exec_ready | input | 1 | Executor accepts the offered word |
| exec_instr | output | 26 | Offered word |
| exec_action | input | 2 | Outcome: 00 remove, 01 requeue, 10 repeat, 11 remove |
| exec_count | input | 7 | New count for requeue or repeat |

## Verification
The assertions assume that a kill word stays on `in_data` without change until it is taken. The internal removal tally is tied to that word. They also assume that `exec_action` and `exec_count` are meaningful whenever `exec_ready` is high.

The random stimulus keeps every input word steady until it is taken. It issues a kill only when enough clog-free entries lie ahead. It issues an unclog only while a clog is stored, and it adds ordinary words only while the reference model shows free space.

The one withdrawn word in the directed part is a kill on an empty ring. It is pulled before any removal has started.

// File: rtl/dock_ring_pkg.sv
package dock_ring_pkg;

  localparam int WORD_W = 26;
  localparam int CNT_W  = 7;
  localparam int CLS_HI = 25;
  localparam int CLS_LO = 23;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_CLOG   = 2'd1,
    KIND_UNCLOG = 2'd2,
    KIND_KILL   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ACT_RETIRE  = 2'b00,
    ACT_REQUEUE = 2'b01,
    ACT_REPEAT  = 2'b10,
    ACT_DROP    = 2'b11
  } act_e;

  // class field of a word
  function automatic kind_e kind_of(input logic [WORD_W-1:0] w);
    case (w[CLS_HI:CLS_LO])
      3'b001:  return KIND_CLOG;
      3'b010:  return KIND_UNCLOG;
      3'b011:  return KIND_KILL;
      default: return KIND_PLAIN;
    endcase
  endfunction

  // replace the count field of a word
  function automatic logic [WORD_W-1:0] set_count(input logic [WORD_W-1:0] w,
                                                  input logic [CNT_W-1:0]  c);
    return {w[WORD_W-1:CNT_W], c};
  endfunction

endpackage

// File: rtl/dock_ring_store.sv
module dock_ring_store #(
  parameter int DEPTH = 8,
  parameter int W     = 26,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_idx,
  input  logic [W-1:0]  wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_idx,
  input  logic [W-1:0]  wb_data,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem_q [DEPTH];

  // port A (tail) wins over port B (head); the controller never aims both at one slot
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wa_en && (wa_idx == AW'(i))) begin
        mem_q[i] <= wa_data;
      end else if (wb_en && (wb_idx == AW'(i))) begin
        mem_q[i] <= wb_data;
      end
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/dock_ring_ptrs.sv
module dock_ring_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] head_idx,
  output logic [AW-1:0] tail_idx,
  output logic [OW-1:0] occ,
  output logic          empty,
  output logic          full
);

  localparam bit            POW2     = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);
  localparam logic [OW-1:0] OCC_FULL = OW'(DEPTH);
  localparam logic [AW-1:0] IDX_LAST = AW'(DEPTH - 1);

  logic [AW-1:0] head_q, tail_q, head_inc, tail_inc, head_d, tail_d;
  logic [OW-1:0] occ_q, occ_d;

  generate
    if (POW2) begin : g_wrap_free
      assign head_inc = head_q + 1'b1;
      assign tail_inc = tail_q + 1'b1;
    end else begin : g_wrap_cmp
      assign head_inc = (head_q == IDX_LAST) ? '0 : head_q + 1'b1;
      assign tail_inc = (tail_q == IDX_LAST) ? '0 : tail_q + 1'b1;
    end
  endgenerate

  always_comb begin
    head_d = pop  ? head_inc : head_q;
    tail_d = push ? tail_inc : tail_q;
    occ_d  = occ_q;
    if (push && !pop) begin
      occ_d = occ_q + 1'b1;
    end else if (pop && !push) begin
      occ_d = occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (pop)         head_q <= head_d;
      if (push)        tail_q <= tail_d;
      if (push != pop) occ_q  <= occ_d;
    end
  end

  assign head_idx = head_q;
  assign tail_idx = tail_q;
  assign occ      = occ_q;
  assign empty    = (occ_q == '0);
  assign full     = (occ_q == OCC_FULL);

endmodule

// File: rtl/dock_ring_ctrl.sv
module dock_ring_ctrl
  import dock_ring_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         empty,
  input  logic         full,
  input  logic [W-1:0] head_word,
  output logic         exec_valid,
  input  logic         exec_ready,
  input  logic [1:0]   exec_action,
  input  logic [CW-1:0] exec_count,
  output logic         push_en,
  output logic [W-1:0] push_word,
  output logic         pop_en,
  output logic         head_we,
  output logic [W-1:0] head_upd
);

  kind_e         in_kind, head_kind;
  act_e          act;
  logic          kill_wait, kill_go, kill_last, unclog_go;
  logic          fire, do_requeue, do_repeat, do_retire, plain_ok;
  logic          lock_q, lock_d;
  logic [CW-1:0] kill_done_q, kill_done_d;
  logic [W-1:0]  head_next;

  always_comb begin
    in_kind    = kind_of(in_data);
    head_kind  = kind_of(head_word);
    act        = act_e'(exec_action);

    // a kill at the insertion point holds back new offers
    kill_wait  = in_valid && (in_kind == KIND_KILL);
    exec_valid = !empty && (head_kind != KIND_CLOG) && (!kill_wait || lock_q);
    fire       = exec_valid && exec_ready;
    do_requeue = fire && (act == ACT_REQUEUE);
    do_repeat  = fire && (act == ACT_REPEAT);
    do_retire  = fire && !do_requeue && !do_repeat;
    head_next  = set_count(head_word, exec_count);

    // kill removes one head entry per cycle once no offer is outstanding
    kill_go    = kill_wait && !lock_q && !empty && (head_kind != KIND_CLOG);
    kill_last  = kill_go && (kill_done_q == in_data[CW-1:0]);

    // unclog pairs with a clog at the execution point
    unclog_go  = in_valid && (in_kind == KIND_UNCLOG) && !empty && (head_kind == KIND_CLOG);

    // plain words and clogs are stored; a requeue owns the tail slot
    plain_ok   = ((in_kind == KIND_PLAIN) || (in_kind == KIND_CLOG)) && !full && !do_requeue;
    in_ready   = plain_ok || kill_last || unclog_go;

    push_en    = do_requeue || (in_valid && plain_ok);
    push_word  = do_requeue ? head_next : in_data;
    pop_en     = do_retire || do_requeue || kill_go || unclog_go;
    head_we    = do_repeat;
    head_upd   = head_next;

    lock_d     = exec_valid && !exec_ready;
    kill_done_d = kill_done_q;
    if (kill_last) begin
      kill_done_d = '0;
    end else if (kill_go) begin
      kill_done_d = kill_done_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q      <= 1'b0;
      kill_done_q <= '0;
    end else begin
      lock_q <= lock_d;
      if (kill_go) kill_done_q <= kill_done_d;
    end
  end

endmodule

// File: rtl/dock_ring.sv
module dock_ring
  import dock_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              exec_valid,
  input  logic              exec_ready,
  output logic [WORD_W-1:0] exec_instr,
  input  logic [1:0]        exec_action,
  input  logic [CNT_W-1:0]  exec_count
);

  logic [AW-1:0]     head_idx, tail_idx;
  logic [OW-1:0]     occ;
  logic              empty, full;
  logic              push_en, pop_en, head_we;
  logic [WORD_W-1:0] push_word, head_upd, head_word;

  dock_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_en),
    .pop      (pop_en),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .occ      (occ),
    .empty    (empty),
    .full     (full)
  );

  dock_ring_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk     (clk),
    .wa_en   (push_en),
    .wa_idx  (tail_idx),
    .wa_data (push_word),
    .wb_en   (head_we),
    .wb_idx  (head_idx),
    .wb_data (head_upd),
    .rd_idx  (head_idx),
    .rd_data (head_word)
  );

  dock_ring_ctrl #(.W(WORD_W), .CW(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .empty       (empty),
    .full        (full),
    .head_word   (head_word),
    .exec_valid  (exec_valid),
    .exec_ready  (exec_ready),
    .exec_action (exec_action),
    .exec_count  (exec_count),
    .push_en     (push_en),
    .push_word   (push_word),
    .pop_en      (pop_en),
    .head_we     (head_we),
    .head_upd    (head_upd)
  );

  assign exec_instr = head_word;

endmodule

// File: rtl/dock_ring_chk.sv
module dock_ring_chk
  import dock_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_data,
  input logic              exec_valid,
  input logic              exec_ready,
  input logic [WORD_W-1:0] exec_instr,
  input logic [1:0]        exec_action,
  input logic [OW-1:0]     occ,
  input logic [WORD_W-1:0] head_word
);

  localparam logic [OW-1:0] OCC_MAX = OW'(DEPTH);

  logic [2:0] in_cls, ex_cls, hd_cls;
  assign in_cls = in_data[CLS_HI:CLS_LO];
  assign ex_cls = exec_instr[CLS_HI:CLS_LO];
  assign hd_cls = head_word[CLS_HI:CLS_LO];

  logic in_take, ex_take, stored_cls;
  assign in_take    = in_valid && in_ready;
  assign ex_take    = exec_valid && exec_ready;
  assign stored_cls = (in_cls != 3'b011) && (in_cls != 3'b010);

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_MAX);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_MAX) && in_take |-> !stored_cls);

  assert_repeat_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ex_take && (exec_action == 2'b10) && !in_take |=> occ == $past(occ));

  assert_requeue_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ex_take && (exec_action == 2'b01) |-> !(in_take && stored_cls));

  assert_offer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid && !exec_ready |=> exec_valid && $stable(exec_instr));

  assert_no_ctrl_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (ex_cls != 3'b001) && (ex_cls != 3'b010) && (ex_cls != 3'b011));

  assert_unclog_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_take && (in_cls == 3'b010) |-> (occ != '0) && (hd_cls == 3'b001));

  assert_kill_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_cls == 3'b011) && !exec_valid |=>
      !exec_valid || !(in_valid && (in_cls == 3'b011)));

endmodule

bind dock_ring dock_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_data     (in_data),
  .exec_valid  (exec_valid),
  .exec_ready  (exec_ready),
  .exec_instr  (exec_instr),
  .exec_action (exec_action),
  .occ         (occ),
  .head_word   (head_word)
);

// File: tb/dock_ring_tb.sv
module dock_ring_tb;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [25:0] in_data;
  logic        exec_valid;
  logic        exec_ready;
  logic [25:0] exec_instr;
  logic [1:0]  exec_action;
  logic [6:0]  exec_count;

  always #5 clk = ~clk;

  dock_ring #(.DEPTH(DEPTH)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .exec_valid  (exec_valid),
    .exec_ready  (exec_ready),
    .exec_instr  (exec_instr),
    .exec_action (exec_action),
    .exec_count  (exec_count)
  );

  int          errors = 0;
  int          checks = 0;
  bit          done   = 0;
  bit          took_in;
  logic [25:0] q[$];

  function automatic logic [2:0] cls(input logic [25:0] w);
    return w[25:23];
  endfunction

  function automatic logic [25:0] with_cnt(input logic [25:0] w, input logic [6:0] c);
    return {w[25:7], c};
  endfunction

  function automatic logic [25:0] plain(input int i);
    return {3'b100, 16'(i * 37), 7'(i)};
  endfunction

  function automatic bit clog_stored();
    foreach (q[i]) if (cls(q[i]) == 3'b001) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit kill_safe(input int n);
    if (q.size() < n + 2) return 1'b0;
    for (int i = 0; i < n + 2; i++) if (cls(q[i]) == 3'b001) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sample at posedge-2, update the reference ring, move to next negedge
  task automatic cycle();
    logic [25:0] w;
    #3;
    took_in = 1'b0;
    if (exec_valid && exec_ready) begin
      w = (q.size() > 0) ? q[0] : 26'h0;
      chk(q.size() > 0 && exec_instr == w, "R2 R4 offer order", 32'(exec_instr), 32'(w));
      case (exec_action)
        2'b01: begin
          chk(!in_ready, "R5 requeue owns tail", 32'(in_ready), 32'd0);
          w = q.pop_front();
          q.push_back(with_cnt(w, exec_count));
        end
        2'b10: q[0] = with_cnt(q[0], exec_count);
        default: void'(q.pop_front());
      endcase
    end
    if (in_valid && in_ready) begin
      took_in = 1'b1;
      case (cls(in_data))
        3'b011: begin
          for (int k = 0; k <= int'(in_data[6:0]); k++) begin
            w = (q.size() > 0) ? q[0] : 26'h0;
            chk(q.size() > 0 && cls(w) != 3'b001, "R9 kill target", 32'(w), 32'(q.size()));
            if (q.size() > 0) void'(q.pop_front());
          end
        end
        3'b010: begin
          w = (q.size() > 0) ? q[0] : 26'h0;
          chk(q.size() > 0 && cls(w) == 3'b001, "R8 unclog pair", 32'(cls(w)), 32'd1);
          if (q.size() > 0) void'(q.pop_front());
        end
        default: begin
          chk(q.size() < DEPTH, "R3 space on accept", 32'(q.size()), DEPTH);
          q.push_back(in_data);
        end
      endcase
    end
    @(negedge clk);
    if (took_in) in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    int n;
    void'($urandom(32'd20240611));
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_data     = '0;
    exec_ready  = 1'b0;
    exec_action = 2'b00;
    exec_count  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!exec_valid, "R1 no offer after reset", 32'(exec_valid), 32'd0);
    chk(in_ready, "R1 ready after reset", 32'(in_ready), 32'd1);
    cycle();

    // fill to capacity with the executor stalled
    for (int i = 0; i < DEPTH; i++) begin
      in_valid = 1'b1;
      in_data  = plain(i);
      cycle();
    end
    in_valid = 1'b1;
    in_data  = plain(DEPTH);
    #1;
    chk(!in_ready, "R3 full ring blocks", 32'(in_ready), 32'd0);
    chk(exec_valid && exec_instr == plain(0), "R2 first offer", 32'(exec_instr), 32'(plain(0)));
    cycle();
    cycle();
    #1;
    chk(exec_valid && exec_instr == plain(0), "R6 offer held", 32'(exec_instr), 32'(plain(0)));
    in_valid = 1'b0;

    // repeat with a new count
    exec_ready  = 1'b1;
    exec_action = 2'b10;
    exec_count  = 7'd5;
    cycle();
    exec_ready = 1'b0;
    #1;
    chk(exec_instr == with_cnt(plain(0), 7'd5), "R4 repeat count", 32'(exec_instr),
        32'(with_cnt(plain(0), 7'd5)));
    cycle();

    // kill count 2 behind an outstanding offer
    in_valid = 1'b1;
    in_data  = {3'b011, 16'h0, 7'd2};
    #1;
    chk(exec_valid, "R10 outstanding offer kept", 32'(exec_valid), 32'd1);
    exec_ready  = 1'b1;
    exec_action = 2'b10;
    exec_count  = 7'd9;
    cycle();
    exec_ready = 1'b0;
    #1;
    chk(!exec_valid, "R10 no new offer under kill", 32'(exec_valid), 32'd0);
    for (int k = 0; k < 20 && in_valid; k++) cycle();
    chk(!in_valid, "R9 kill taken", 32'(in_valid), 32'd0);
    #1;
    chk(exec_valid && exec_instr == plain(3), "R9 three removed", 32'(exec_instr), 32'(plain(3)));

    // clog freezes the head
    in_valid = 1'b1;
    in_data  = {3'b001, 23'h0};
    cycle();
    exec_ready  = 1'b1;
    exec_action = 2'b00;
    repeat (DEPTH - 3) cycle();
    exec_ready = 1'b0;
    #1;
    chk(!exec_valid && q.size() == 1, "R7 clog not offered", 32'(exec_valid), 32'd0);
    in_valid = 1'b1;
    in_data  = plain(20);
    cycle();
    #1;
    chk(!exec_valid, "R7 entry behind clog held", 32'(exec_valid), 32'd0);
    in_valid = 1'b1;
    in_data  = {3'b010, 23'h0};
    #1;
    chk(in_ready, "R8 unclog meets clog", 32'(in_ready), 32'd1);
    cycle();
    #1;
    chk(exec_valid && exec_instr == plain(20), "R8 released", 32'(exec_instr), 32'(plain(20)));

    // kill waits on an empty ring
    exec_ready  = 1'b1;
    exec_action = 2'b00;
    cycle();
    exec_ready = 1'b0;
    in_valid   = 1'b1;
    in_data    = {3'b011, 16'h0, 7'd0};
    repeat (3) begin
      #1;
      chk(!in_ready, "R9 kill waits when empty", 32'(in_ready), 32'd0);
      cycle();
    end
    in_valid = 1'b0;

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      if (!in_valid) begin
        r = int'($urandom % 100);
        n = int'($urandom % 3);
        if (clog_stored() && r < 15) begin
          in_valid = 1'b1;
          in_data  = {3'b010, 23'($urandom)};
        end else if (r < 10 && kill_safe(n)) begin
          in_valid = 1'b1;
          in_data  = {3'b011, 16'($urandom), 7'(n)};
        end else if (r < 18 && !clog_stored() && q.size() < DEPTH) begin
          in_valid = 1'b1;
          in_data  = {3'b001, 23'($urandom)};
        end else if (r < 70 && q.size() < DEPTH) begin
          in_valid = 1'b1;
          in_data  = 26'($urandom);
          if (in_data[25:23] inside {3'b001, 3'b010, 3'b011}) in_data[25] = 1'b1;
        end
      end
      exec_ready  = ($urandom % 100) < 55;
      exec_action = 2'($urandom);
      exec_count  = 7'($urandom);
      cycle();
    end

    // drain
    exec_ready  = 1'b1;
    exec_action = 2'b00;
    for (int k = 0; k < 400 && (q.size() > 0 || in_valid); k++) begin
      if (!in_valid && clog_stored()) begin
        in_valid = 1'b1;
        in_data  = {3'b010, 23'h0};
      end
      cycle();
    end
    #1;
    chk(q.size() == 0 && !exec_valid, "R2 drained", 32'(q.size()), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule